// File: doc/BRIEF.md
# Rename-to-ROB Skid Buffer

This block sits between the rename stage and the reorder buffer. Every cycle it accepts a group of up to `W` renamed instructions. Each lane carries a valid bit, a thread number, a sequence number and a squashed bit. The block hands up to `W` instructions to the reorder buffer, always in program order. Instructions that cannot be handed over in the current cycle are parked in an internal queue, and queued instructions always go before anything newly arriving.

Squashed instructions are thrown away at two points: when they would be parked, and when they come up for insertion. Two more controls shape the traffic. A stage-wide squash input holds the whole stage. A per-thread squashing vector suppresses insertion for the threads it names. A separate per-thread kill request marks parked entries that are younger than a given sequence number, so that they are never inserted. For each thread the block also keeps the sequence number of the most recently inserted instruction.

Top module: `rob_skid_buffer`

## Requirements
- R1: After a synchronous reset, every `rob_valid` lane is 0, `overflow` is 0, every `youngest_seq` entry is 0, and the queue is empty.
- R2: When `squash_all` is 0, the block processes min(`W`, queued + valid incoming) instructions in a cycle. On the next cycle, output lane k reports the k-th processed instruction. A lane is valid only if that instruction was inserted; lanes beyond the processed count are invalid.
- R3: Queued entries are processed first, oldest first, before any lane of the current group. Incoming instructions are taken in ascending lane order, and invalid lanes are skipped.
- R4: Incoming instructions not processed in a cycle are appended to the queue in order. Any such instruction with `grp_squashed`=1 is discarded instead of queued.
- R5: A processed instruction is dropped, with its lane invalid and nothing kept, in any of three cases: its squashed bit is 1, its thread's bit in `thread_squashing` is 1 in that cycle, or it is a killed queued entry.
- R6: While `squash_all` is 1, no lane is valid on the next cycle, and no queued entry is removed. Every valid incoming instruction with squashed bit 0 is appended to the queue.
- R7: `youngest_seq[t]` takes, one cycle later, the sequence number of the last instruction of thread t inserted in a cycle; the highest inserted lane wins. Otherwise it holds.
- R8: With `kill_valid`=1, every entry queued at the start of the cycle whose thread equals `kill_tid` and whose sequence number is strictly greater than `kill_seq` is killed. A killed entry still occupies a processing slot when drained, but it is never inserted. Entries of other threads, and entries with a sequence number at or below the point, are unaffected.
- R9: If appends would exceed the free space left after this cycle's drain, the excess (youngest) instructions are discarded and `overflow` is 1 for exactly the next cycle. The queue never holds more than `DEPTH` entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | W | Per-lane valid of the incoming rename group |
| grp_tid | input | W×TIDW | Per-lane thread number |
| grp_seq | input | W×SEQW | Per-lane sequence number |
| grp_squashed | input | W | Per-lane squashed bit |
| squash_all | input | 1 | Whole stage is squashing |
| thread_squashing | input | NTHR | Per-thread squashing state |
| kill_valid | input | 1 | Kill request for queued entries |
| kill_tid | input | TIDW | Thread of the kill request |
| kill_seq | input | SEQW | Kill point; entries strictly younger are killed |
| rob_valid | output | W | Per-lane insert strobe toward the reorder buffer |
| rob_tid | output | W×TIDW | Thread number of each inserted lane |
| rob_seq | output | W×SEQW | Sequence number of each inserted lane |
| youngest_seq | output | NTHR×SEQW | Sequence number of the last inserted instruction per thread |
| overflow | output | 1 | One-cycle pulse when appends were discarded for lack of space |

## Verification
The hardest situation to reach is a full queue that must discard appends. Because `DEPTH` is at least twice `W`, this can only happen while the stage-wide squash holds draining off. The stimulus therefore keeps `squash_all` high across three full groups: the first two fill the queue exactly, and the third overflows. It then releases the squash and offers one new instruction, to show that the parked entries still leave in order ahead of it. Killing queued entries is reached the same way. The queue is first filled under `squash_all`, and the kill is issued while draining is still blocked, so the killed entries are still present when they come up for processing.

// File: rtl/rob_skid_pkg.sv
package rob_skid_pkg;

  // Where an output lane's candidate instruction comes from.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_HELD = 2'd1,
    SRC_NEW  = 2'd2
  } lane_src_e;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/skid_store.sv
module skid_store #(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  parameter int TIDW  = 1,
  parameter int SEQW  = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int WCW  = $clog2(W + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      kill_valid,
  input  logic [TIDW-1:0]           kill_tid,
  input  logic [SEQW-1:0]           kill_seq,
  input  logic [WCW-1:0]            pop_n,
  input  logic [WCW-1:0]            push_n,
  input  logic [W-1:0][TIDW-1:0]    push_tid,
  input  logic [W-1:0][SEQW-1:0]    push_seq,
  output logic [CW-1:0]             held_n,
  output logic [W-1:0][TIDW-1:0]    rd_tid,
  output logic [W-1:0][SEQW-1:0]    rd_seq,
  output logic [W-1:0]              rd_live
);

  logic [TIDW-1:0]  tid_mem [DEPTH];
  logic [SEQW-1:0]  seq_mem [DEPTH];
  logic [DEPTH-1:0] alive_q, alive_d, kill_hit;
  logic [AW-1:0]    head_q, tail;
  logic [CW-1:0]    count_q;

  assign held_n = count_q;
  assign tail   = head_q + count_q[AW-1:0];

  // Kill compare against every stored entry.
  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_kill
      assign kill_hit[gi] = kill_valid && (tid_mem[gi] == kill_tid) &&
                            (seq_mem[gi] > kill_seq);
    end
  endgenerate

  // Read window at the oldest entries.
  generate
    for (gi = 0; gi < W; gi++) begin : g_rd
      logic [AW-1:0] idx;
      assign idx         = head_q + AW'(gi);
      assign rd_tid[gi]  = tid_mem[idx];
      assign rd_seq[gi]  = seq_mem[idx];
      assign rd_live[gi] = alive_q[idx] & ~kill_hit[idx];
    end
  endgenerate

  always_comb begin
    alive_d = alive_q & ~kill_hit;
    for (int k = 0; k < W; k++) begin
      if (k < int'(push_n)) alive_d[tail + AW'(k)] = 1'b1;
    end
  end

  // Payload storage: no reset, written only at the tail.
  always_ff @(posedge clk) begin
    for (int k = 0; k < W; k++) begin
      if (k < int'(push_n)) begin
        tid_mem[tail + AW'(k)] <= push_tid[k];
        seq_mem[tail + AW'(k)] <= push_seq[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      count_q <= '0;
      alive_q <= '0;
    end else begin
      head_q  <= head_q + AW'(pop_n);
      count_q <= count_q - CW'(pop_n) + CW'(push_n);
      alive_q <= alive_d;
    end
  end

  // R9: occupancy bounded by the depth.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

  // R3: never drain more than is held.
  assert_pop_within_held_R3: assert property (@(posedge clk) disable iff (rst)
    CW'(pop_n) <= count_q);

endmodule

// File: rtl/skid_merge.sv
module skid_merge
  import rob_skid_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  parameter int NTHR  = 2,
  parameter int TIDW  = 1,
  parameter int SEQW  = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int WCW  = $clog2(W + 1)
) (
  input  logic [W-1:0]              in_valid,
  input  logic [W-1:0][TIDW-1:0]    in_tid,
  input  logic [W-1:0][SEQW-1:0]    in_seq,
  input  logic [W-1:0]              in_sqd,
  input  logic                      all_squash,
  input  logic [NTHR-1:0]           thr_squash,
  input  logic [CW-1:0]             held_n,
  input  logic [W-1:0][TIDW-1:0]    rd_tid,
  input  logic [W-1:0][SEQW-1:0]    rd_seq,
  input  logic [W-1:0]              rd_live,
  output logic [W-1:0]              ins_valid,
  output logic [W-1:0][TIDW-1:0]    ins_tid,
  output logic [W-1:0][SEQW-1:0]    ins_seq,
  output logic [WCW-1:0]            pop_n,
  output logic [WCW-1:0]            push_n,
  output logic [W-1:0][TIDW-1:0]    push_tid,
  output logic [W-1:0][SEQW-1:0]    push_seq,
  output logic                      ovf
);

  // Incoming group packed down to its valid lanes.
  logic [TIDW-1:0] c_tid [W];
  logic [SEQW-1:0] c_seq [W];
  logic            c_sqd [W];
  int              n_in;

  always_comb begin
    n_in = 0;
    for (int j = 0; j < W; j++) begin
      c_tid[j] = '0;
      c_seq[j] = '0;
      c_sqd[j] = 1'b0;
    end
    for (int j = 0; j < W; j++) begin
      if (in_valid[j]) begin
        c_tid[n_in] = in_tid[j];
        c_seq[n_in] = in_seq[j];
        c_sqd[n_in] = in_sqd[j];
        n_in = n_in + 1;
      end
    end
  end

  function automatic logic thr_quiet(input logic [TIDW-1:0] t,
                                     input logic [NTHR-1:0] sq);
    thr_quiet = 1'b1;
    for (int i = 0; i < NTHR; i++) begin
      if (int'(t) == i) thr_quiet = ~sq[i];
    end
  endfunction

  lane_src_e src [W];
  int        take_held, n_proc, first_left, n_push, free_slots;
  logic      dead;

  always_comb begin
    take_held  = all_squash ? 0 : min_int(int'(held_n), W);
    n_proc     = all_squash ? 0 : min_int(W, int'(held_n) + n_in);
    first_left = n_proc - take_held;
    ins_valid  = '0;
    ins_tid    = '0;
    ins_seq    = '0;
    dead       = 1'b0;
    for (int k = 0; k < W; k++) begin
      if (k < take_held)   src[k] = SRC_HELD;
      else if (k < n_proc) src[k] = SRC_NEW;
      else                 src[k] = SRC_NONE;
      case (src[k])
        SRC_HELD: begin
          ins_tid[k] = rd_tid[k];
          ins_seq[k] = rd_seq[k];
          dead       = ~rd_live[k];
        end
        SRC_NEW: begin
          ins_tid[k] = c_tid[k - take_held];
          ins_seq[k] = c_seq[k - take_held];
          dead       = c_sqd[k - take_held];
        end
        default: dead = 1'b1;
      endcase
      ins_valid[k] = ~dead & thr_quiet(ins_tid[k], thr_squash);
    end

    // Leftover incoming instructions, squashed ones discarded.
    n_push   = 0;
    push_tid = '0;
    push_seq = '0;
    for (int j = 0; j < W; j++) begin
      if (j >= first_left && j < n_in && !c_sqd[j]) begin
        push_tid[n_push] = c_tid[j];
        push_seq[n_push] = c_seq[j];
        n_push = n_push + 1;
      end
    end
    free_slots = DEPTH - (int'(held_n) - take_held);
    ovf        = (n_push > free_slots);
    push_n     = WCW'(ovf ? free_slots : n_push);
    pop_n      = WCW'(take_held);
  end

endmodule

// File: rtl/seq_tracker.sv
module seq_tracker #(
  parameter int W    = 4,
  parameter int NTHR = 2,
  parameter int TIDW = 1,
  parameter int SEQW = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [W-1:0]              ins_valid,
  input  logic [W-1:0][TIDW-1:0]    ins_tid,
  input  logic [W-1:0][SEQW-1:0]    ins_seq,
  output logic [NTHR-1:0][SEQW-1:0] youngest
);

  logic [NTHR-1:0][SEQW-1:0] young_d;

  always_comb begin
    young_d = youngest;
    for (int k = 0; k < W; k++) begin
      for (int t = 0; t < NTHR; t++) begin
        if (ins_valid[k] && int'(ins_tid[k]) == t) young_d[t] = ins_seq[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) youngest <= '0;
    else     youngest <= young_d;
  end

endmodule

// File: rtl/rob_skid_buffer.sv
module rob_skid_buffer #(
  parameter int W     = 4,
  parameter int DEPTH = 8,
  parameter int NTHR  = 2,
  parameter int SEQW  = 16,
  localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [W-1:0]              grp_valid,
  input  logic [W-1:0][TIDW-1:0]    grp_tid,
  input  logic [W-1:0][SEQW-1:0]    grp_seq,
  input  logic [W-1:0]              grp_squashed,
  input  logic                      squash_all,
  input  logic [NTHR-1:0]           thread_squashing,
  input  logic                      kill_valid,
  input  logic [TIDW-1:0]           kill_tid,
  input  logic [SEQW-1:0]           kill_seq,
  output logic [W-1:0]              rob_valid,
  output logic [W-1:0][TIDW-1:0]    rob_tid,
  output logic [W-1:0][SEQW-1:0]    rob_seq,
  output logic [NTHR-1:0][SEQW-1:0] youngest_seq,
  output logic                      overflow
);

  localparam int CW  = $clog2(DEPTH + 1);
  localparam int WCW = $clog2(W + 1);

  logic [CW-1:0]           held_n;
  logic [W-1:0][TIDW-1:0]  rd_tid, push_tid, ins_tid;
  logic [W-1:0][SEQW-1:0]  rd_seq, push_seq, ins_seq;
  logic [W-1:0]            rd_live, ins_valid;
  logic [WCW-1:0]          pop_n, push_n;
  logic                    ovf;

  skid_store #(.W(W), .DEPTH(DEPTH), .TIDW(TIDW), .SEQW(SEQW)) store_i (
    .clk(clk), .rst(rst),
    .kill_valid(kill_valid), .kill_tid(kill_tid), .kill_seq(kill_seq),
    .pop_n(pop_n), .push_n(push_n), .push_tid(push_tid), .push_seq(push_seq),
    .held_n(held_n), .rd_tid(rd_tid), .rd_seq(rd_seq), .rd_live(rd_live)
  );

  skid_merge #(.W(W), .DEPTH(DEPTH), .NTHR(NTHR), .TIDW(TIDW), .SEQW(SEQW)) merge_i (
    .in_valid(grp_valid), .in_tid(grp_tid), .in_seq(grp_seq), .in_sqd(grp_squashed),
    .all_squash(squash_all), .thr_squash(thread_squashing),
    .held_n(held_n), .rd_tid(rd_tid), .rd_seq(rd_seq), .rd_live(rd_live),
    .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_seq(ins_seq),
    .pop_n(pop_n), .push_n(push_n), .push_tid(push_tid), .push_seq(push_seq),
    .ovf(ovf)
  );

  seq_tracker #(.W(W), .NTHR(NTHR), .TIDW(TIDW), .SEQW(SEQW)) track_i (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_seq(ins_seq),
    .youngest(youngest_seq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rob_valid <= '0;
      rob_tid   <= '0;
      rob_seq   <= '0;
      overflow  <= 1'b0;
    end else begin
      rob_valid <= ins_valid;
      rob_tid   <= ins_tid;
      rob_seq   <= ins_seq;
      overflow  <= ovf;
    end
  end

  // R6: a stage-wide squash cycle yields no insertions.
  assert_quiet_on_all_squash_R6: assert property (@(posedge clk) disable iff (rst)
    squash_all |=> (rob_valid == '0));

  // R9: overflow can only follow a cycle in which draining was held off.
  assert_ovf_only_when_held_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(squash_all));

  // R5: a squashing thread gets no insertion in the following cycle.
  genvar gt, gk;
  generate
    for (gt = 0; gt < NTHR; gt++) begin : g_thr
      for (gk = 0; gk < W; gk++) begin : g_lane
        assert_thread_quiet_R5: assert property (@(posedge clk) disable iff (rst)
          thread_squashing[gt] |=> !(rob_valid[gk] && int'(rob_tid[gk]) == gt));
      end
    end
  endgenerate

endmodule

// File: tb/rob_skid_buffer_tb.sv
`timescale 1ns/1ps
module rob_skid_buffer_tb_top;

  localparam int W = 4, DEPTH = 8, NTHR = 2, SEQW = 16, TIDW = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0]              grp_valid, grp_squashed;
  logic [W-1:0][TIDW-1:0]    grp_tid;
  logic [W-1:0][SEQW-1:0]    grp_seq;
  logic                      squash_all, kill_valid;
  logic [NTHR-1:0]           thread_squashing;
  logic [TIDW-1:0]           kill_tid;
  logic [SEQW-1:0]           kill_seq;
  logic [W-1:0]              rob_valid;
  logic [W-1:0][TIDW-1:0]    rob_tid;
  logic [W-1:0][SEQW-1:0]    rob_seq;
  logic [NTHR-1:0][SEQW-1:0] youngest_seq;
  logic                      overflow;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  rob_skid_buffer #(.W(W), .DEPTH(DEPTH), .NTHR(NTHR), .SEQW(SEQW)) dut_i (
    .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_tid(grp_tid),
    .grp_seq(grp_seq), .grp_squashed(grp_squashed), .squash_all(squash_all),
    .thread_squashing(thread_squashing), .kill_valid(kill_valid),
    .kill_tid(kill_tid), .kill_seq(kill_seq), .rob_valid(rob_valid),
    .rob_tid(rob_tid), .rob_seq(rob_seq), .youngest_seq(youngest_seq),
    .overflow(overflow)
  );

  task automatic clr_in();
    grp_valid = '0; grp_squashed = '0; grp_tid = '0; grp_seq = '0;
    squash_all = 1'b0; thread_squashing = '0;
    kill_valid = 1'b0; kill_tid = '0; kill_seq = '0;
  endtask

  task automatic put(input int k, input int tid, input int seq, input bit sqd);
    grp_valid[k] = 1'b1; grp_tid[k] = TIDW'(tid);
    grp_seq[k] = SEQW'(seq); grp_squashed[k] = sqd;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk_lane(input string req, input int k, input bit v,
                          input int tid, input int seq);
    total++;
    if (rob_valid[k] !== v || (v && (int'(rob_tid[k]) != tid || int'(rob_seq[k]) != seq))) begin
      bad++;
      $display("FAIL %s lane%0d actual v=%0b t=%0d s=%0d expected v=%0b t=%0d s=%0d",
               req, k, rob_valid[k], rob_tid[k], rob_seq[k], v, tid, seq);
    end
  endtask

  task automatic chk_none(input string req);
    total++;
    if (rob_valid !== '0) begin
      bad++;
      $display("FAIL %s actual rob_valid=%b expected 0", req, rob_valid);
    end
  endtask

  task automatic chk_young(input string req, input int t, input int seq);
    total++;
    if (int'(youngest_seq[t]) != seq) begin
      bad++;
      $display("FAIL %s youngest[%0d] actual=%0d expected=%0d", req, t, youngest_seq[t], seq);
    end
  endtask

  task automatic chk_ovf(input string req, input bit v);
    total++;
    if (overflow !== v) begin
      bad++;
      $display("FAIL %s overflow actual=%0b expected=%0b", req, overflow, v);
    end
  endtask

  task automatic t_reset();
    chk_none("R1"); chk_ovf("R1", 1'b0);
    chk_young("R1", 0, 0); chk_young("R1", 1, 0);
  endtask

  task automatic t_pass();
    clr_in();
    for (int k = 0; k < 4; k++) put(k, 0, k + 1, 1'b0);
    cyc(); clr_in();
    for (int k = 0; k < 4; k++) chk_lane("R2", k, 1'b1, 0, k + 1);
    chk_young("R7", 0, 4);
  endtask

  task automatic t_sparse();
    clr_in(); put(1, 1, 10, 1'b0); put(3, 1, 11, 1'b0);
    cyc(); clr_in();
    chk_lane("R3", 0, 1'b1, 1, 10); chk_lane("R3", 1, 1'b1, 1, 11);
    chk_lane("R2", 2, 1'b0, 0, 0);  chk_lane("R2", 3, 1'b0, 0, 0);
    chk_young("R7", 1, 11);
  endtask

  task automatic t_hold_then_drain();
    clr_in(); squash_all = 1'b1;
    put(0, 0, 20, 1'b0); put(1, 0, 21, 1'b1); put(2, 0, 22, 1'b0); put(3, 0, 23, 1'b0);
    cyc(); clr_in();
    chk_none("R6");
    for (int k = 0; k < 4; k++) put(k, 0, 30 + k, 1'b0);
    cyc(); clr_in();
    chk_lane("R3", 0, 1'b1, 0, 20); chk_lane("R4", 1, 1'b1, 0, 22);
    chk_lane("R3", 2, 1'b1, 0, 23); chk_lane("R3", 3, 1'b1, 0, 30);
    chk_young("R7", 0, 30);
    cyc();
    chk_lane("R4", 0, 1'b1, 0, 31); chk_lane("R4", 1, 1'b1, 0, 32);
    chk_lane("R4", 2, 1'b1, 0, 33); chk_lane("R2", 3, 1'b0, 0, 0);
    chk_young("R7", 0, 33);
  endtask

  task automatic t_thread_squash();
    clr_in(); thread_squashing = 2'b10;
    put(0, 0, 40, 1'b0); put(1, 1, 41, 1'b0); put(2, 0, 42, 1'b1); put(3, 1, 43, 1'b0);
    cyc(); clr_in();
    chk_lane("R5", 0, 1'b1, 0, 40); chk_lane("R5", 1, 1'b0, 0, 0);
    chk_lane("R5", 2, 1'b0, 0, 0);  chk_lane("R5", 3, 1'b0, 0, 0);
    chk_young("R5", 1, 11); chk_young("R7", 0, 40);
    cyc();
    chk_none("R5");
  endtask

  task automatic t_kill();
    clr_in(); squash_all = 1'b1;
    put(0, 0, 50, 1'b0); put(1, 0, 51, 1'b0); put(2, 1, 52, 1'b0); put(3, 0, 53, 1'b0);
    cyc(); clr_in();
    chk_none("R6");
    squash_all = 1'b1; kill_valid = 1'b1; kill_tid = 1'b0; kill_seq = 16'd50;
    cyc(); clr_in();
    chk_none("R6");
    cyc();
    chk_lane("R8", 0, 1'b1, 0, 50); chk_lane("R8", 1, 1'b0, 0, 0);
    chk_lane("R8", 2, 1'b1, 1, 52); chk_lane("R8", 3, 1'b0, 0, 0);
    chk_young("R7", 1, 52);
    cyc();
    chk_none("R8");
  endtask

  task automatic t_overflow();
    clr_in(); squash_all = 1'b1;
    for (int k = 0; k < 4; k++) put(k, 0, 60 + k, 1'b0);
    cyc(); chk_ovf("R9", 1'b0);
    for (int k = 0; k < 4; k++) put(k, 0, 64 + k, 1'b0);
    cyc(); chk_ovf("R9", 1'b0);
    for (int k = 0; k < 4; k++) put(k, 0, 68 + k, 1'b0);
    cyc(); clr_in();
    chk_ovf("R9", 1'b1); chk_none("R6");
    put(0, 1, 80, 1'b0);
    cyc(); clr_in();
    chk_ovf("R9", 1'b0);
    for (int k = 0; k < 4; k++) chk_lane("R3", k, 1'b1, 0, 60 + k);
    cyc();
    for (int k = 0; k < 4; k++) chk_lane("R9", k, 1'b1, 0, 64 + k);
    cyc();
    chk_lane("R3", 0, 1'b1, 1, 80);
    for (int k = 1; k < 4; k++) chk_lane("R9", k, 1'b0, 0, 0);
    chk_young("R7", 1, 80); chk_young("R7", 0, 67);
    cyc();
    chk_none("R9");
  endtask

  initial begin
    clr_in();
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_pass();
    t_sparse();
    t_hold_then_drain();
    t_thread_squash();
    t_kill();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule